// File: doc/BRIEF.md
# Stack Frame Sequencer

This block carries out the stack-touching instructions of a small 8-bit processor core: it pops return frames into the 16-bit program counter, saves and restores the status byte and 16-bit register pairs, and moves values between the stack pointer and a register pair. The core's decoder raises `start` together with a 3-bit opcode and the current register-pair value. The block then runs its own memory accesses over a byte-wide data port and raises `done` once the fixed cycle budget of that opcode has elapsed. It holds the program counter, status byte, stack pointer and interrupt-in-service flag itself. It returns register-pair results through `pair_o` with a one-cycle `pair_wr_o` strobe.

Stack addresses wrap modulo 2^16. The memory port is synchronous: the byte at the address presented in one cycle appears on `mem_rdata_i` in the next cycle. A `start` that arrives while an operation is running is dropped. Cycle budgets in the requirements count the clock edge that samples `start` as edge 1. The operation is done after edge N, which means `done_o` is high and every architectural output shows its new value.

Top module: `stk_seq`

## Requirements
- R1: After reset, pc_o, psw_o, sp_o and pair_o are 0, and nmi_srv_o, busy_o, done_o and pair_wr_o are low.
- R2: Opcode 0 (return) sets pc_o low byte from memory at SP and high byte from SP+1, and adds 2 to SP. It finishes after edge 6.
- R3: Opcode 1 (interrupt return) loads pc_o as in R2, loads psw_o from SP+2, adds 3 to SP and clears nmi_srv_o. It finishes after edge 8.
- R4: Opcode 2 writes psw_o to SP-1 and subtracts 1 from SP. It finishes after edge 2.
- R5: Opcode 3 writes the high byte of pair_i (bits 15:8) to SP-1 and the low byte to SP-2, and subtracts 2 from SP. It finishes after edge 4.
- R6: Opcode 4 loads psw_o from memory at SP and adds 1 to SP. It finishes after edge 4.
- R7: Opcode 5 puts {byte at SP+1, byte at SP} on pair_o, pulses pair_wr_o with done_o, and adds 2 to SP. It finishes after edge 6.
- R8: Opcode 6 copies pair_i into SP and finishes after edge 8. Opcode 7 puts SP on pair_o with a pair_wr_o pulse and finishes after edge 6.
- R9: Every stack address and SP update wraps modulo 2^16 (0xFFFF+1 = 0x0000, 0x0000-1 = 0xFFFF).
- R10: While busy_o is high, start is ignored: the running operation and its results are unchanged, and no second operation follows. done_o and pair_wr_o are single-cycle pulses.
- R11: A read presents its address for one cycle and captures mem_rdata_i in the following cycle.
- R12: nmi_take_i high at a clock edge sets nmi_srv_o. At an edge where it coincides with an interrupt-return commit, the set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operation request strobe |
| op_i | input | 3 | Operation code |
| pair_i | input | 16 | Register-pair value sampled with start |
| nmi_take_i | input | 1 | Sets the interrupt-in-service flag |
| mem_addr_o | output | 16 | Data-memory byte address |
| mem_wdata_o | output | 8 | Data-memory write byte |
| mem_we_o | output | 1 | Data-memory write enable |
| mem_rdata_i | input | 8 | Data-memory read byte, one cycle after address |
| pc_o | output | 16 | Program counter |
| psw_o | output | 8 | Status byte |
| sp_o | output | 16 | Stack pointer |
| pair_o | output | 16 | Register-pair result |
| pair_wr_o | output | 1 | Register-pair result strobe |
| nmi_srv_o | output | 1 | Interrupt-in-service flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation complete pulse |

## Verification
The hardest cases to reach are the stack pointer wrapping across the 0xFFFF/0x0000 boundary in the middle of a multi-byte access, and a `start` landing while an operation is still running. The stimulus loads SP with 0xFFFF and with 0x0001 through the pair-to-SP copy, then pops and pushes register pairs so that the two bytes of one frame sit on opposite sides of the wrap. A second start with a different opcode is then injected two cycles into the long SP load. The bench confirms that the original result stands and that nothing runs afterwards.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_RET       = 3'd0,
        OP_RETI      = 3'd1,
        OP_PUSH_PSW  = 3'd2,
        OP_PUSH_PAIR = 3'd3,
        OP_POP_PSW   = 3'd4,
        OP_POP_PAIR  = 3'd5,
        OP_SP_LOAD   = 3'd6,
        OP_SP_READ   = 3'd7
    } stk_op_e;

    localparam int CNT_W = 4;

    typedef struct packed {
        logic [CNT_W-1:0] len;   // total clock budget
        logic [1:0]       n_rd;  // bytes read upward from SP
        logic [1:0]       n_wr;  // bytes written downward from SP-1
    } op_attr_t;

endpackage

// File: rtl/stk_decode.sv
module stk_decode
    import stk_pkg::*;
(
    input  stk_op_e  op_i,
    output op_attr_t attr_o
);

    always_comb begin
        attr_o = '0;
        unique case (op_i)
            OP_RET:       attr_o = '{len: 4'd6, n_rd: 2'd2, n_wr: 2'd0};
            OP_RETI:      attr_o = '{len: 4'd8, n_rd: 2'd3, n_wr: 2'd0};
            OP_PUSH_PSW:  attr_o = '{len: 4'd2, n_rd: 2'd0, n_wr: 2'd1};
            OP_PUSH_PAIR: attr_o = '{len: 4'd4, n_rd: 2'd0, n_wr: 2'd2};
            OP_POP_PSW:   attr_o = '{len: 4'd4, n_rd: 2'd1, n_wr: 2'd0};
            OP_POP_PAIR:  attr_o = '{len: 4'd6, n_rd: 2'd2, n_wr: 2'd0};
            OP_SP_LOAD:   attr_o = '{len: 4'd8, n_rd: 2'd0, n_wr: 2'd0};
            OP_SP_READ:   attr_o = '{len: 4'd6, n_rd: 2'd0, n_wr: 2'd0};
            default:      attr_o = '{len: 4'd2, n_rd: 2'd0, n_wr: 2'd0};
        endcase
    end

    // every budget must leave room for the accesses it schedules (R2..R8)
    always_comb begin
        a_r2_budget_fits: assert ({2'b00, attr_o.n_rd} + 4'd2 <= attr_o.len
                                  && {2'b00, attr_o.n_wr} + 4'd1 <= attr_o.len);
    end

endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen
    import stk_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             active_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  op_attr_t         attr_i,
    input  logic [AW-1:0]    sp_i,
    input  logic [DW-1:0]    psw_i,
    input  logic [2*DW-1:0]  pair_i,
    output logic [AW-1:0]    addr_o,
    output logic [DW-1:0]    wdata_o,
    output logic             we_o,
    output logic             cap_en_o,
    output logic [1:0]       cap_idx_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rd_last;
    logic [CNT_W-1:0] wr_last;

    always_comb begin
        rd_last   = CNT_W'(attr_i.n_rd);
        wr_last   = CNT_W'(attr_i.n_wr);
        addr_o    = sp_i;
        wdata_o   = '0;
        we_o      = 1'b0;
        cap_en_o  = 1'b0;
        cap_idx_o = '0;
        if (active_i) begin
            if (cnt_i >= ONE && cnt_i <= wr_last) begin
                // downward writes: SP-1 first, then SP-2 (wraps mod 2^AW)
                we_o    = 1'b1;
                addr_o  = sp_i - AW'(cnt_i);
                if (attr_i.n_wr == 2'd1)
                    wdata_o = psw_i;
                else if (cnt_i == ONE)
                    wdata_o = pair_i[2*DW-1:DW];
                else
                    wdata_o = pair_i[DW-1:0];
            end else if (cnt_i >= ONE && cnt_i <= rd_last) begin
                // upward reads: SP, SP+1, SP+2
                addr_o = sp_i + AW'(cnt_i - ONE);
            end
            // byte for the address of cycle k is captured in cycle k+1
            if (cnt_i >= CNT_W'(2) && cnt_i <= rd_last + ONE) begin
                cap_en_o  = 1'b1;
                cap_idx_o = 2'(cnt_i - CNT_W'(2));
            end
        end
    end

endmodule

// File: rtl/stk_rdbuf.sv
module stk_rdbuf #(
    parameter int DW = 8,
    parameter int NB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en_i,
    input  logic [1:0]       cap_idx_i,
    input  logic [DW-1:0]    data_i,
    output logic [NB*DW-1:0] bytes_o
);

    for (genvar g = 0; g < NB; g++) begin : g_byte
        logic [DW-1:0] byte_d, byte_q;

        always_comb begin
            byte_d = byte_q;
            if (cap_en_i && cap_idx_i == 2'(g))
                byte_d = data_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) byte_q <= '0;
            else        byte_q <= byte_d;
        end

        assign bytes_o[g*DW +: DW] = byte_q;
    end

    // R11: capture slots never exceed the frame size
    a_r11_cap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en_i |-> (32'(cap_idx_i) < NB));

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [2:0]    op_i,
    input  logic [2*DW-1:0] pair_i,
    input  logic          nmi_take_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          mem_we_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] psw_o,
    output logic [AW-1:0] sp_o,
    output logic [2*DW-1:0] pair_o,
    output logic          pair_wr_o,
    output logic          nmi_srv_o,
    output logic          busy_o,
    output logic          done_o
);

    localparam int PW = 2 * DW;
    localparam int NB = 3;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        stk_op_e          op;
        logic [PW-1:0]    pair_in;
        logic [AW-1:0]    pc;
        logic [DW-1:0]    psw;
        logic [AW-1:0]    sp;
        logic [PW-1:0]    pair_out;
        logic             pair_wr;
        logic             done;
        logic             nmi;
    } st_t;

    st_t st_d, st_q;

    op_attr_t         attr;
    logic             cap_en;
    logic [1:0]       cap_idx;
    logic [NB*DW-1:0] rbytes;
    logic [DW-1:0]    b0, b1, b2;

    stk_decode u_dec (
        .op_i   (st_q.op),
        .attr_o (attr)
    );

    stk_addr_gen #(.AW(AW), .DW(DW)) u_agen (
        .active_i  (st_q.busy),
        .cnt_i     (st_q.cnt),
        .attr_i    (attr),
        .sp_i      (st_q.sp),
        .psw_i     (st_q.psw),
        .pair_i    (st_q.pair_in),
        .addr_o    (mem_addr_o),
        .wdata_o   (mem_wdata_o),
        .we_o      (mem_we_o),
        .cap_en_o  (cap_en),
        .cap_idx_o (cap_idx)
    );

    stk_rdbuf #(.DW(DW), .NB(NB)) u_rbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en_i  (cap_en),
        .cap_idx_i (cap_idx),
        .data_i    (mem_rdata_i),
        .bytes_o   (rbytes)
    );

    assign b0 = rbytes[0*DW +: DW];
    assign b1 = rbytes[1*DW +: DW];
    assign b2 = rbytes[2*DW +: DW];

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.pair_wr = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy    = 1'b1;
                st_d.cnt     = CNT_W'(1);
                st_d.op      = stk_op_e'(op_i);
                st_d.pair_in = pair_i;
            end
        end else if (st_q.cnt == attr.len - CNT_W'(1)) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
            st_d.done = 1'b1;
            unique case (st_q.op)
                OP_RET: begin
                    st_d.pc = {b1, b0};
                    st_d.sp = st_q.sp + AW'(2);
                end
                OP_RETI: begin
                    st_d.pc  = {b1, b0};
                    st_d.psw = b2;
                    st_d.sp  = st_q.sp + AW'(3);
                    st_d.nmi = 1'b0;
                end
                OP_PUSH_PSW:  st_d.sp = st_q.sp - AW'(1);
                OP_PUSH_PAIR: st_d.sp = st_q.sp - AW'(2);
                OP_POP_PSW: begin
                    st_d.psw = b0;
                    st_d.sp  = st_q.sp + AW'(1);
                end
                OP_POP_PAIR: begin
                    st_d.pair_out = {b1, b0};
                    st_d.pair_wr  = 1'b1;
                    st_d.sp       = st_q.sp + AW'(2);
                end
                OP_SP_LOAD: st_d.sp = AW'(st_q.pair_in);
                OP_SP_READ: begin
                    st_d.pair_out = PW'(st_q.sp);
                    st_d.pair_wr  = 1'b1;
                end
                default: ;
            endcase
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        // a fresh interrupt acceptance wins over a clearing return (R12)
        if (nmi_take_i)
            st_d.nmi = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o      = st_q.pc;
    assign psw_o     = st_q.psw;
    assign sp_o      = st_q.sp;
    assign pair_o    = st_q.pair_out;
    assign pair_wr_o = st_q.pair_wr;
    assign nmi_srv_o = st_q.nmi;
    assign busy_o    = st_q.busy;
    assign done_o    = st_q.done;

    // R10: completion strobe lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: a start during an operation leaves the latched opcode alone
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(st_q.op));

    // R9: the stack pointer moves only at a completion
    a_r9_sp_moves_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp_o) |-> done_o);

    // R3: the in-service flag drops only when a return completes
    a_r3_nmi_clear_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_srv_o) |-> done_o);

    // R5: memory is written only inside an operation
    a_r5_write_in_op: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    // R7: register-pair strobe coincides with completion
    a_r7_pair_wr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        pair_wr_o |-> done_o);

endmodule

// File: tb/stk_seq_tb_top.sv
`timescale 1ns/1ps
module stk_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] pair_in = 16'h0;
    logic        nmi_take = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic [15:0] pc, sp, pair_out;
    logic [7:0]  psw;
    logic        pair_wr, nmi_srv, busy, done;

    always #2 clk = ~clk;  // 250 MHz

    stk_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .pair_i(pair_in),
        .nmi_take_i(nmi_take), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_we_o(mem_we), .mem_rdata_i(mem_rdata), .pc_o(pc), .psw_o(psw),
        .sp_o(sp), .pair_o(pair_out), .pair_wr_o(pair_wr), .nmi_srv_o(nmi_srv),
        .busy_o(busy), .done_o(done)
    );

    // memory: 512 bytes, aliased on address bits 8:0, one-cycle read latency
    logic [7:0] mem [512];
    logic [7:0] mdl  [512];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[8:0]];
    end

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_pc = 0, m_sp = 0, m_pair = 0;
    logic [7:0]  m_psw = 0;
    logic        m_nmi = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int budget(input logic [2:0] o);
        case (o)
            3'd0: return 6;  3'd1: return 8;  3'd2: return 2;  3'd3: return 4;
            3'd4: return 4;  3'd5: return 6;  3'd6: return 8;  default: return 6;
        endcase
    endfunction

    function automatic string tag(input logic [2:0] o);
        case (o)
            3'd0: return "R2"; 3'd1: return "R3"; 3'd2: return "R4"; 3'd3: return "R5";
            3'd4: return "R6"; 3'd5: return "R7"; default: return "R8";
        endcase
    endfunction

    // run one operation and compare against the reference model
    task automatic run_op(input logic [2:0] o, input logic [15:0] v);
        int k;
        logic pw_exp;
        logic [15:0] a1, a2;
        string t;
        t = tag(o);
        pw_exp = 1'b0;
        a1 = m_sp - 16'd1;
        a2 = m_sp - 16'd2;
        case (o)
            3'd0: begin m_pc = {mdl[9'(m_sp + 16'd1)], mdl[9'(m_sp)]}; m_sp = m_sp + 16'd2; end
            3'd1: begin
                m_pc  = {mdl[9'(m_sp + 16'd1)], mdl[9'(m_sp)]};
                m_psw = mdl[9'(m_sp + 16'd2)];
                m_sp  = m_sp + 16'd3;
                m_nmi = 1'b0;
            end
            3'd2: begin mdl[9'(a1)] = m_psw; m_sp = a1; end
            3'd3: begin mdl[9'(a1)] = v[15:8]; mdl[9'(a2)] = v[7:0]; m_sp = a2; end
            3'd4: begin m_psw = mdl[9'(m_sp)]; m_sp = m_sp + 16'd1; end
            3'd5: begin
                m_pair = {mdl[9'(m_sp + 16'd1)], mdl[9'(m_sp)]};
                m_sp = m_sp + 16'd2; pw_exp = 1'b1;
            end
            3'd6: m_sp = v;
            default: begin m_pair = m_sp; pw_exp = 1'b1; end
        endcase
        @(negedge clk); start = 1'b1; op = o; pair_in = v;
        @(negedge clk); start = 1'b0;
        k = 1;
        while (!done && k < 20) begin @(negedge clk); k++; end
        chk({t, " cycles"}, k, budget(o));
        chk({t, " pc"}, pc, m_pc);
        chk({t, " psw"}, psw, m_psw);
        chk({"R9 ", t, " sp"}, sp, m_sp);
        chk({t, " nmi"}, nmi_srv, m_nmi);
        chk({t, " pair_wr"}, pair_wr, pw_exp);
        if (pw_exp) chk({t, " pair"}, pair_out, m_pair);
        if (o == 3'd2) chk("R4 mem SP-1", mem[9'(a1)], mdl[9'(a1)]);
        if (o == 3'd3) begin
            chk("R5 mem SP-1 high", mem[9'(a1)], v[15:8]);
            chk("R5 mem SP-2 low", mem[9'(a2)], v[7:0]);
        end
        @(negedge clk);
        chk("R10 done single pulse", done, 1'b0);
        chk("R10 pair_wr single pulse", pair_wr, 1'b0);
    endtask

    localparam int NV = 15;
    localparam logic [18:0] VEC [NV] = '{
        {3'd6, 16'h0010},  // SP <- 0x0010
        {3'd4, 16'h0000},  // pop status
        {3'd5, 16'h0000},  // pop pair
        {3'd3, 16'hBEEF},  // push pair
        {3'd2, 16'h0000},  // push status
        {3'd0, 16'h0000},  // return
        {3'd7, 16'h0000},  // pair <- SP
        {3'd6, 16'h0040},
        {3'd1, 16'h0000},  // interrupt return
        {3'd6, 16'hFFFF},  // wrap cases (R9)
        {3'd5, 16'h0000},
        {3'd6, 16'h0001},
        {3'd3, 16'hA55A},
        {3'd2, 16'h0000},
        {3'd7, 16'h0000}
    };

    initial begin
        #400000;
        n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'(i * 7 + 3);
            mdl[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pc", pc, 0);
        chk("R1 psw", psw, 0);
        chk("R1 sp", sp, 0);
        chk("R1 pair", pair_out, 0);
        chk("R1 flags", {nmi_srv, busy, done, pair_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][18:16] == 3'd1) begin
                // R12: acceptance sets the in-service flag before the return
                nmi_take = 1'b1; @(negedge clk); nmi_take = 1'b0;
                m_nmi = 1'b1;
                chk("R12 nmi set", nmi_srv, 1'b1);
            end
            run_op(VEC[i][18:16], VEC[i][15:0]);  // R11 exercised by every read
        end

        // R10: second start while busy is dropped
        @(negedge clk); start = 1'b1; op = 3'd6; pair_in = 16'h0123;
        @(negedge clk); start = 1'b0;
        @(negedge clk); @(negedge clk);
        start = 1'b1; op = 3'd2; pair_in = 16'h0777;
        @(negedge clk); start = 1'b0;
        begin
            int k = 4;
            while (!done && k < 20) begin @(negedge clk); k++; end
            chk("R10 budget kept", k, 8);
        end
        chk("R10 sp from first op", sp, 16'h0123);
        repeat (12) @(negedge clk);
        chk("R10 no follow-on op", {busy, sp}, {1'b0, 16'h0123});
        chk("R10 no stray write", mem[9'h122], mdl[9'h122]);
        m_sp = 16'h0123;

        // R12: set wins over the clearing interrupt return at the same edge
        @(negedge clk); start = 1'b1; op = 3'd1;
        @(negedge clk); start = 1'b0;
        repeat (6) @(negedge clk);
        nmi_take = 1'b1;
        @(negedge clk); nmi_take = 1'b0;
        chk("R12 done at edge 8", done, 1'b1);
        chk("R12 set priority", nmi_srv, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule